// File: doc/BRIEF.md
# Serial Peripheral Slave with Sticky Status Word

This block is a serial peripheral slave for a system bus. Software puts a character into a transmit holding register and reads received characters from a receive holding register. A single shift register moves data in both directions while the external master drives the serial clock and holds the active-low select low. SCLK, MOSI and the select are brought into the system clock domain through two-flop synchronisers, so the system clock must run at least four times faster than SCLK. The link runs in clock mode 0: MOSI is sampled on the rising SCLK edge, MISO changes on the falling edge, and the most significant bit goes first. The character length is a parameter from 8 to 16 bits.

A 32-bit status word gathers the block's events. Some flags track a condition, such as whether the receive register holds unread data, whether the transmit register can take a new character, and whether the whole transmit path has drained. Other flags are sticky and latch an event until software reads the status word: a receive overrun, a character started with no fresh transmit data, the select released part-way through a character, and any release of the select. If the master starts a character and no new data has been written, the block shifts out the last transmitted value again, or zero if nothing has been sent since reset.

The bus has four word addresses: 0 writes the transmit register, 1 reads the receive register, 2 reads the status word, and 3 writes the control word, where bit 0 is the enable. Reads are combinational. A read takes effect on the clock edge that ends the cycle in which busRe is high.

Top module: `spi_slave_status`

## Requirements
- R1: After reset the status word reads 0. Only bits 0, 1, 3, 8, 9, 10, 11 and 16 can ever be 1. Bit 2 (mode fault) is always 0.
- R2: Bit 0 (receive full) sets when a completed character enters the receive register and clears when address 1 is read. The received value holds the MOSI bits, first bit in the most significant position.
- R3: Bit 3 (overrun) sets when the receive register is loaded while bit 0 is already 1 and address 1 is not being read. It stays set until a status read.
- R4: Bit 1 (transmit ready) is 0 while the block is disabled. It sets when the block is enabled, clears when address 0 is written, and sets again when that character moves into the shift register.
- R5: Bit 9 (transmit drained) clears on a write to address 0 and is 0 while the block is disabled. It sets only when the holding register and the shift register are both empty and GAP_CYCLES further clock cycles have passed. It stays 0 while a character is being shifted.
- R6: Bit 10 (underrun) sets when the first SCLK rise of a character occurs and no fresh data was loaded for that character. That character repeats the last transmitted value, or zero after reset. The flag clears on a status read.
- R7: Bit 11 (frame error) sets when the select rises after at least one, but fewer than CHAR_BITS, bits of the current character have been shifted. It clears on a status read.
- R8: Bit 8 (select released) sets on every rising edge of csN and clears on a status read.
- R9: Bit 16 shows the enable written through address 3. Writes to address 0 while the block is disabled are ignored.
- R10: MISO carries the written transmit character in mode 0, most significant bit first, valid before each rising SCLK edge.
- R11: If a sticky flag's setting event falls in the same cycle as the status read that would clear it, the flag stays set afterwards.
- R12: Address 1 returns the receive register zero-extended to 32 bits. Address 2 returns the status word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busWe | input | 1 | Bus write strobe |
| busRe | input | 1 | Bus read strobe |
| busAddr | input | 2 | Word address: 0 transmit, 1 receive, 2 status, 3 control |
| busWdata | input | BUS_W | Bus write data |
| busRdata | output | 32 | Bus read data, combinational |
| sclk | input | 1 | Serial clock from the master |
| mosi | input | 1 | Serial data in |
| csN | input | 1 | Active-low select |
| miso | output | 1 | Serial data out |

## Verification
The sensitive collision is a release of the select, which sets bit 8, in the same system clock cycle as the status read that clears bit 8. The bench raises csN and then issues a status read at each of six offsets after the release, which moves the read across the synchroniser delay. For each offset it works out whether the read fell before, on, or after the cycle in which the flag sets. From that it predicts whether bit 8 shows in the read data and whether it survives into a second read. Exactly one of the two must show the flag. A second collision, a receive load arriving while the receive flag is already set, is provoked by two back-to-back characters with no read in between, and the bench expects the overrun bit.

// File: rtl/spi_slave_status_pkg.sv
package spi_slave_status_pkg;

  localparam logic [1:0] ADDR_TX     = 2'd0;
  localparam logic [1:0] ADDR_RX     = 2'd1;
  localparam logic [1:0] ADDR_STATUS = 2'd2;
  localparam logic [1:0] ADDR_CTRL   = 2'd3;

  localparam int BIT_RXFULL  = 0;
  localparam int BIT_TXREADY = 1;
  localparam int BIT_MODEF   = 2;
  localparam int BIT_OVR     = 3;
  localparam int BIT_CSROSE  = 8;
  localparam int BIT_DRAINED = 9;
  localparam int BIT_UDR     = 10;
  localparam int BIT_FRAME   = 11;
  localparam int BIT_ENABLED = 16;

  localparam logic [31:0] STATUS_MASK = 32'h0001_0F0B;

  // control -> datapath
  typedef struct packed {
    logic enable;
    logic wrTx;
  } ctlStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic rxLoad;
    logic freshLoad;
    logic underrun;
    logic csRise;
    logic frameErr;
    logic idleDone;
  } dpEvent_t;

endpackage

// File: rtl/spi_slave_status_sync.sv
module spi_slave_status_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= {STAGES{RESET_VAL}};
    else       chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/spi_slave_status_dp.sv
module spi_slave_status_dp
  import spi_slave_status_pkg::*;
#(
  parameter int CHAR_BITS  = 8,
  parameter int GAP_CYCLES = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctlStrobe_t           strb,
  input  logic [CHAR_BITS-1:0] txData,
  input  logic                 sclk,
  input  logic                 mosi,
  input  logic                 csN,
  output logic                 miso,
  output logic [CHAR_BITS-1:0] rxData,
  output logic                 txFull,
  output dpEvent_t             evt
);
  localparam int CNT_W = $clog2(CHAR_BITS + 1);
  localparam int GAP_W = $clog2(GAP_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(CHAR_BITS - 1);
  localparam logic [GAP_W-1:0] GAP_END  = GAP_W'(GAP_CYCLES);
  localparam int NPINS = 3;
  localparam logic [NPINS-1:0] PIN_IDLE = 3'b100; // {csN, mosi, sclk}

  logic [NPINS-1:0] pinRaw, pinSync;
  assign pinRaw = {csN, mosi, sclk};

  for (genvar g = 0; g < NPINS; g++) begin : gSync
    spi_slave_status_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(PIN_IDLE[g])) uSync (
      .clk (clk),
      .rstN(rstN),
      .d   (pinRaw[g]),
      .q   (pinSync[g])
    );
  end

  logic sclkS, mosiS, csS;
  assign sclkS = pinSync[0];
  assign mosiS = pinSync[1];
  assign csS   = pinSync[2];

  logic sclkQ, csQ;
  logic [CHAR_BITS-1:0] txHold, txShift, lastTx, rxShift, rxHold;
  logic [CNT_W-1:0] bitCnt;
  logic [GAP_W-1:0] gapCnt;
  logic shiftBusy, staleLoad;

  logic en, active, sclkRise, sclkFall, csFall, csRiseRaw, charDone, loadNow;
  assign en        = strb.enable;
  assign active    = ~csS;
  assign sclkRise  = en & active & sclkS & ~sclkQ;
  assign sclkFall  = en & active & ~sclkS & sclkQ;
  assign csFall    = ~csS & csQ;
  assign csRiseRaw = csS & ~csQ;
  assign charDone  = sclkRise && (bitCnt == LAST_BIT);
  assign loadNow   = en && (csFall || charDone);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkQ <= 1'b0;
      csQ   <= 1'b1;
    end else begin
      sclkQ <= sclkS;
      csQ   <= csS;
    end
  end

  // transmit holding register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txHold <= '0;
      txFull <= 1'b0;
    end else if (!en) begin
      txFull <= 1'b0;
    end else if (strb.wrTx) begin
      txHold <= txData;
      txFull <= 1'b1;
    end else if (loadNow) begin
      txFull <= 1'b0;
    end
  end

  // shift register, outbound half
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
      lastTx  <= '0;
    end else if (loadNow) begin
      txShift <= txFull ? txHold : lastTx;
      if (txFull) lastTx <= txHold;
    end else if (sclkFall && bitCnt != '0) begin
      txShift <= {txShift[CHAR_BITS-2:0], 1'b0};
    end
  end

  // bit counter and load bookkeeping
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt    <= '0;
      shiftBusy <= 1'b0;
      staleLoad <= 1'b0;
    end else if (!en || csRiseRaw) begin
      bitCnt    <= '0;
      shiftBusy <= 1'b0;
      staleLoad <= 1'b0;
    end else begin
      if (csFall)        bitCnt <= '0;
      else if (sclkRise) bitCnt <= charDone ? '0 : bitCnt + 1'b1;
      if (loadNow) begin
        shiftBusy <= txFull;
        staleLoad <= ~txFull;
      end else if (sclkRise && bitCnt == '0) begin
        staleLoad <= 1'b0;
      end
    end
  end

  // shift register, inbound half
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
      rxHold  <= '0;
    end else if (sclkRise) begin
      rxShift <= {rxShift[CHAR_BITS-2:0], mosiS};
      if (charDone) rxHold <= {rxShift[CHAR_BITS-2:0], mosiS};
    end
  end

  // drain gap counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                             gapCnt <= '0;
    else if (!en || txFull || shiftBusy)   gapCnt <= '0;
    else if (gapCnt != GAP_END)            gapCnt <= gapCnt + 1'b1;
  end

  assign miso   = txShift[CHAR_BITS-1];
  assign rxData = rxHold;

  always_comb begin
    evt.rxLoad    = charDone;
    evt.freshLoad = loadNow && txFull;
    evt.underrun  = sclkRise && (bitCnt == '0) && staleLoad;
    evt.csRise    = csRiseRaw;
    evt.frameErr  = en && csRiseRaw && (bitCnt != '0);
    evt.idleDone  = en && !txFull && !shiftBusy && (gapCnt == GAP_END);
  end
endmodule

// File: rtl/spi_slave_status_ctl.sv
module spi_slave_status_ctl
  import spi_slave_status_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        busWe,
  input  logic        busRe,
  input  logic [1:0]  busAddr,
  input  logic        enBit,
  input  dpEvent_t    evt,
  output ctlStrobe_t  strb,
  output logic [31:0] statusWord
);
  logic en, enNext, ctrlWr, rdRx, rdStatus;
  logic rxFull, ovr, txReady, drained, csRose, udr, frameErr;

  assign ctrlWr   = busWe && busAddr == ADDR_CTRL;
  assign rdRx     = busRe && busAddr == ADDR_RX;
  assign rdStatus = busRe && busAddr == ADDR_STATUS;
  assign enNext   = ctrlWr ? enBit : en;

  always_comb begin
    strb.enable = en;
    strb.wrTx   = busWe && busAddr == ADDR_TX && en;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      en       <= 1'b0;
      rxFull   <= 1'b0;
      ovr      <= 1'b0;
      txReady  <= 1'b0;
      drained  <= 1'b0;
      csRose   <= 1'b0;
      udr      <= 1'b0;
      frameErr <= 1'b0;
    end else begin
      en       <= enNext;
      rxFull   <= evt.rxLoad | (rxFull & ~rdRx);
      ovr      <= (evt.rxLoad & rxFull & ~rdRx) | (ovr & ~rdStatus);
      csRose   <= evt.csRise   | (csRose & ~rdStatus);
      udr      <= evt.underrun | (udr & ~rdStatus);
      frameErr <= evt.frameErr | (frameErr & ~rdStatus);

      if (!enNext)                 txReady <= 1'b0;
      else if (ctrlWr && !en)      txReady <= 1'b1;
      else if (strb.wrTx)          txReady <= 1'b0;
      else if (evt.freshLoad)      txReady <= 1'b1;

      if (!enNext)                 drained <= 1'b0;
      else if (strb.wrTx)          drained <= 1'b0;
      else if (evt.idleDone)       drained <= 1'b1;
    end
  end

  always_comb begin
    statusWord              = '0;
    statusWord[BIT_RXFULL]  = rxFull;
    statusWord[BIT_TXREADY] = txReady;
    statusWord[BIT_MODEF]   = 1'b0;
    statusWord[BIT_OVR]     = ovr;
    statusWord[BIT_CSROSE]  = csRose;
    statusWord[BIT_DRAINED] = drained;
    statusWord[BIT_UDR]     = udr;
    statusWord[BIT_FRAME]   = frameErr;
    statusWord[BIT_ENABLED] = en;
  end
endmodule

// File: rtl/spi_slave_status.sv
module spi_slave_status
  import spi_slave_status_pkg::*;
#(
  parameter int CHAR_BITS  = 8,
  parameter int GAP_CYCLES = 4,
  parameter int BUS_W      = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busWe,
  input  logic             busRe,
  input  logic [1:0]       busAddr,
  input  logic [BUS_W-1:0] busWdata,
  output logic [31:0]      busRdata,
  input  logic             sclk,
  input  logic             mosi,
  input  logic             csN,
  output logic             miso
);
  ctlStrobe_t           strb;
  dpEvent_t             evt;
  logic [31:0]          statusWord;
  logic [CHAR_BITS-1:0] rxData;
  logic                 txFull;

  spi_slave_status_ctl uCtl (
    .clk       (clk),
    .rstN      (rstN),
    .busWe     (busWe),
    .busRe     (busRe),
    .busAddr   (busAddr),
    .enBit     (busWdata[0]),
    .evt       (evt),
    .strb      (strb),
    .statusWord(statusWord)
  );

  spi_slave_status_dp #(.CHAR_BITS(CHAR_BITS), .GAP_CYCLES(GAP_CYCLES)) uDp (
    .clk   (clk),
    .rstN  (rstN),
    .strb  (strb),
    .txData(busWdata[CHAR_BITS-1:0]),
    .sclk  (sclk),
    .mosi  (mosi),
    .csN   (csN),
    .miso  (miso),
    .rxData(rxData),
    .txFull(txFull),
    .evt   (evt)
  );

  always_comb begin
    case (busAddr)
      ADDR_RX:     busRdata = 32'(rxData);
      ADDR_STATUS: busRdata = statusWord;
      default:     busRdata = '0;
    endcase
  end
endmodule

// File: rtl/spi_slave_status_chk.sv
module spi_slave_status_chk
  import spi_slave_status_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic        busWe,
  input logic        busRe,
  input logic [1:0]  busAddr,
  input logic        enBit,
  input logic [31:0] statusWord,
  input dpEvent_t    evt,
  input ctlStrobe_t  strb,
  input logic        txFull
);
  logic rdRx, rdStatus, ctrlWr;
  assign rdRx     = busRe && busAddr == ADDR_RX;
  assign rdStatus = busRe && busAddr == ADDR_STATUS;
  assign ctrlWr   = busWe && busAddr == ADDR_CTRL;

  p_reserved_zero_r1: assert property (@(posedge clk) disable iff (!rstN)
    (statusWord & ~STATUS_MASK) == 32'h0);

  p_rxfull_set_r2: assert property (@(posedge clk) disable iff (!rstN)
    evt.rxLoad |=> statusWord[BIT_RXFULL]);

  p_rxfull_clear_r2: assert property (@(posedge clk) disable iff (!rstN)
    rdRx && !evt.rxLoad |=> !statusWord[BIT_RXFULL]);

  p_overrun_set_r3: assert property (@(posedge clk) disable iff (!rstN)
    evt.rxLoad && statusWord[BIT_RXFULL] && !rdRx |=> statusWord[BIT_OVR]);

  p_ready_tracks_r4: assert property (@(posedge clk) disable iff (!rstN)
    statusWord[BIT_TXREADY] == (statusWord[BIT_ENABLED] && !txFull));

  p_drained_clear_r5: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrTx |=> !statusWord[BIT_DRAINED]);

  p_underrun_set_r6: assert property (@(posedge clk) disable iff (!rstN)
    evt.underrun |=> statusWord[BIT_UDR]);

  p_frame_set_r7: assert property (@(posedge clk) disable iff (!rstN)
    evt.frameErr |=> statusWord[BIT_FRAME]);

  p_csrose_set_r8: assert property (@(posedge clk) disable iff (!rstN)
    evt.csRise |=> statusWord[BIT_CSROSE]);

  p_enable_follows_r9: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWr |=> statusWord[BIT_ENABLED] == $past(enBit));

  p_read_clears_r11: assert property (@(posedge clk) disable iff (!rstN)
    rdStatus && !evt.csRise |=> !statusWord[BIT_CSROSE]);

  p_event_wins_r11: assert property (@(posedge clk) disable iff (!rstN)
    rdStatus && evt.underrun |=> statusWord[BIT_UDR]);
endmodule

bind spi_slave_status spi_slave_status_chk uChk (
  .clk       (clk),
  .rstN      (rstN),
  .busWe     (busWe),
  .busRe     (busRe),
  .busAddr   (busAddr),
  .enBit     (busWdata[0]),
  .statusWord(statusWord),
  .evt       (evt),
  .strb      (strb),
  .txFull    (txFull)
);

// File: tb/tb_spi_slave_status.sv
module tb_spi_slave_status;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 5;
  localparam int CB = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busWe = 1'b0, busRe = 1'b0;
  logic [1:0] busAddr = 2'd0;
  logic [15:0] busWdata = '0;
  logic [31:0] busRdata;
  logic sclk = 1'b0, mosi = 1'b0, csN = 1'b1;
  logic miso;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  spi_slave_status #(.CHAR_BITS(CB), .GAP_CYCLES(4), .BUS_W(16)) dut (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busRe(busRe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .sclk(sclk), .mosi(mosi),
    .csN(csN), .miso(miso)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    busWe = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic busRead(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    busRe = 1'b1; busAddr = a;
    #1 d = busRdata;
    @(negedge clk);
    busRe = 1'b0;
  endtask

  task automatic csLow();
    @(negedge clk); csN = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic csHigh();
    @(negedge clk); csN = 1'b1;
    repeat (12) @(negedge clk);
  endtask

  task automatic shiftBits(input logic [CB-1:0] d, input int n, output logic [CB-1:0] got);
    got = '0;
    for (int i = 0; i < n; i++) begin
      mosi = d[CB-1-i];
      repeat (HALF) @(negedge clk);
      got = {got[CB-2:0], miso};
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (HALF) @(negedge clk);
  endtask

  task automatic xfer(input logic [CB-1:0] d, output logic [CB-1:0] got);
    csLow();
    shiftBits(d, CB, got);
    csHigh();
  endtask

  task automatic report();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      report();
    end
  end

  initial begin
    logic [31:0] rd, rd2;
    logic [CB-1:0] got, lastT;

    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state, R12 receive read path
    busRead(2'd2, rd); check("R1 reset status", rd, 32'h0);
    busRead(2'd1, rd); check("R12 reset rx", rd, 32'h0);

    // R9 write while disabled ignored; enable
    busWrite(2'd0, 16'h005A);
    busWrite(2'd3, 16'h0001);
    repeat (10) @(negedge clk);
    busRead(2'd2, rd); check("R4 R5 R9 enabled idle", rd, 32'h0001_0202);

    // R6 first underrun replays zero
    xfer(8'hA5, got);
    check("R6 R9 miso zero after reset", 32'(got), 32'h0);
    busRead(2'd2, rd); check("R6 R8 R2 status after underrun", rd, 32'h0001_0703);
    busRead(2'd2, rd); check("R8 cleared on read", rd, 32'h0001_0203);
    busRead(2'd1, rd); check("R2 R12 rx value", rd, 32'h0000_00A5);
    busRead(2'd2, rd); check("R2 rx full cleared", rd, 32'h0001_0202);

    // sweep of characters
    for (int i = 0; i < 16; i++) begin
      logic [CB-1:0] t, m;
      t = 8'(i * 37 + 5);
      m = 8'((i * 91) ^ 8'h3C);
      busWrite(2'd0, 16'(t));
      busRead(2'd2, rd); check("R4 R5 after tx write", rd, 32'h0001_0000);
      csLow();
      busRead(2'd2, rd); check("R5 busy shifting", rd, 32'h0001_0002);
      shiftBits(m, CB, got);
      csHigh();
      check("R10 miso char", 32'(got), 32'(t));
      busRead(2'd2, rd); check("R2 R8 after char", rd, 32'h0001_0303);
      busRead(2'd1, rd); check("R2 rx char", rd, 32'(m));
      busRead(2'd2, rd); check("R8 R2 cleared", rd, 32'h0001_0202);
      lastT = t;
    end

    // R3 overrun
    busWrite(2'd0, 16'h0011);
    xfer(8'h96, got);
    busWrite(2'd0, 16'h0022);
    xfer(8'h69, got);
    check("R10 second char", 32'(got), 32'h22);
    busRead(2'd2, rd); check("R3 overrun", rd, 32'h0001_030B);
    busRead(2'd2, rd); check("R3 overrun cleared", rd, 32'h0001_0203);
    busRead(2'd1, rd); check("R3 rx holds newest", rd, 32'h0000_0069);
    lastT = 8'h22;

    // R6 underrun replays last value
    xfer(8'hC3, got);
    check("R6 replay last", 32'(got), 32'(lastT));
    busRead(2'd2, rd); check("R6 underrun", rd, 32'h0001_0703);
    busRead(2'd1, rd);
    busRead(2'd2, rd); check("R6 underrun cleared", rd, 32'h0001_0202);

    // R7 frame error
    busWrite(2'd0, 16'h00F0);
    csLow();
    shiftBits(8'hE0, 3, got);
    csHigh();
    busRead(2'd2, rd); check("R7 frame error", rd, 32'h0001_0B02);
    busRead(2'd2, rd); check("R7 frame cleared", rd, 32'h0001_0202);

    // R11 collision sweep: status read at offset k after select release
    for (int k = 0; k < 6; k++) begin
      csLow();
      busRead(2'd2, rd);
      @(negedge clk); csN = 1'b1;
      repeat (k) @(negedge clk);
      busRe = 1'b1; busAddr = 2'd2;
      #1 rd = busRdata;
      @(negedge clk); busRe = 1'b0;
      repeat (8) @(negedge clk);
      busRead(2'd2, rd2);
      check("R11 R8 first read", 32'(rd[8]), (k >= 3) ? 32'h1 : 32'h0);
      check("R11 flag kept", 32'(rd2[8]), (k <= 2) ? 32'h1 : 32'h0);
    end

    // R9 disable and ignored write
    busWrite(2'd3, 16'h0000);
    repeat (2) @(negedge clk);
    busRead(2'd2, rd); check("R4 R5 R9 disabled", rd, 32'h0);
    busWrite(2'd0, 16'h0077);
    busWrite(2'd3, 16'h0001);
    repeat (10) @(negedge clk);
    busRead(2'd2, rd); check("R9 write ignored while disabled", rd, 32'h0001_0202);

    finished = 1;
    report();
  end
endmodule